// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers interrupt-causing events from a set of audio DMA bus-master channels. Each channel keeps its own lower-level cause register with one bit per kind of event. The block also shows a single read-only summary word that has one bit per channel. A summary bit is the "something pending" flag for its channel. It is set by any event on that channel. It stays set until software reads that channel's own cause register, and that read clears the channel's cause bits and its summary bit together. Reading the summary word changes nothing.

Software uses the block as follows. It takes the single interrupt line `irq_o` and reads the summary word to see which channels are pending. It then reads the cause register of each flagged channel, and that read both reports and acknowledges the events. Reads use a plain strobe-and-address port. The data is returned registered one cycle after the strobe, and it reflects the state before that cycle's update.

Top module: `irq_status_agg`

## Requirements
- R1: After reset every cause bit, every summary bit, `irq_o` and `rd_data` are 0.
- R2: An event pulse on cause bit k of channel c sets bit k of that channel's cause register (bits 1:0 of the word read at address `CH_BASE`+c). It also sets summary bit c+2, so channels 7..0 occupy summary bits 9..2.
- R3: A set summary bit stays set until its channel's cause register is read. Reading the summary word (address `SUM_ADDR`) has no side effect on any state.
- R4: Reading channel c's cause register returns its cause bits and clears them and summary bit c+2 on the same edge. No other channel is affected.
- R5: When an event and a clearing read of the same channel fall in the same cycle, the event's cause bits stay set and the summary bit stays 1. Older cause bits are cleared, because the read reported them.
- R6: Summary bits 31:10 and the spare bits 1:0 always read 0. Cause-register bits above the cause field read 0, and addresses that map to no register read 0.
- R7: `irq_o` is 1 exactly when the summary word is nonzero. It is driven from a flop and changes on the same edge as the summary bits.
- R8: `rd_data` holds the word addressed by the strobe of the previous cycle, as it stood before that edge. It is 0 after any cycle without a strobe.
- R9: Events on different cause bits of one channel accumulate in its cause register until the channel's register is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | NUM_CH x CAUSE_W | One-cycle event pulses, per channel and cause bit |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Registered OR of all summary bits |

## Verification
On every cycle the assertions check several properties. A summary bit holds unless its channel is read, a read without an event clears it, and an event always sets it. They also check that `irq_o` agrees with the summary word, that summary reads show zeros in the reserved and spare positions, and that an idle cycle returns zero data. Some results can only be shown by the bench scenarios, which compare against a model: the exact cause bits returned by a channel read, how bits accumulate across events, and the outcome when an event collides with a clear. The same holds for the fact that a summary read leaves the state untouched.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        DEC_NONE = 2'd0,
        DEC_SUM  = 2'd1,
        DEC_CHAN = 2'd2
    } dec_kind_e;
endpackage

// File: rtl/irq_rd_decode.sv
module irq_rd_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int NUM_CH   = 8,
    parameter int SUM_ADDR = 0,
    parameter int CH_BASE  = 16,
    parameter int IDX_W    = 3
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output dec_kind_e         kind,
    output logic [IDX_W-1:0]  chan_idx,
    output logic [NUM_CH-1:0] clr_vec
);
    logic [ADDR_W-1:0] offset;

    assign offset   = rd_addr - ADDR_W'(CH_BASE);
    assign chan_idx = offset[IDX_W-1:0];

    always_comb begin
        kind = DEC_NONE;
        if (rd_en) begin
            if (rd_addr == ADDR_W'(SUM_ADDR)) begin
                kind = DEC_SUM;
            end else if ((rd_addr >= ADDR_W'(CH_BASE)) && (int'(offset) < NUM_CH)) begin
                kind = DEC_CHAN;
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
        assign clr_vec[c] = (kind == DEC_CHAN) && (chan_idx == IDX_W'(c));
    end
endmodule

// File: rtl/irq_chan_status.sv
module irq_chan_status #(
    parameter int CAUSE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] ev,
    input  logic               clr,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [CAUSE_W-1:0] cause_nxt
);
    // A new event outranks a clearing read in the same cycle.
    always_comb begin
        cause_nxt = ev | (clr ? '0 : cause_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_nxt;
        end
    end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int CAUSE_W  = 2,
    parameter int SUM_OFS  = 2,
    parameter int ADDR_W   = 5,
    parameter int SUM_ADDR = 0,
    parameter int CH_BASE  = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CH-1:0][CAUSE_W-1:0]  ev_i,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            irq_o
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    dec_kind_e                         kind;
    logic [IDX_W-1:0]                  chan_idx;
    logic [NUM_CH-1:0]                 clr_vec;
    logic [NUM_CH-1:0][CAUSE_W-1:0]    cause_q;
    logic [NUM_CH-1:0][CAUSE_W-1:0]    cause_nxt;
    logic [NUM_CH-1:0]                 sum_vec;
    logic [NUM_CH-1:0]                 sum_nxt;
    logic [DATA_W-1:0]                 rd_word;
    logic [DATA_W-1:0]                 rd_data_q;
    logic                              irq_q;

    irq_rd_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_CH  (NUM_CH),
        .SUM_ADDR(SUM_ADDR),
        .CH_BASE (CH_BASE),
        .IDX_W   (IDX_W)
    ) u_dec (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .kind    (kind),
        .chan_idx(chan_idx),
        .clr_vec (clr_vec)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        irq_chan_status #(
            .CAUSE_W(CAUSE_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev_i[c]),
            .clr      (clr_vec[c]),
            .cause_q  (cause_q[c]),
            .cause_nxt(cause_nxt[c])
        );
        assign sum_vec[c] = |cause_q[c];
        assign sum_nxt[c] = |cause_nxt[c];
    end

    always_comb begin
        rd_word = '0;
        unique case (kind)
            DEC_SUM:  rd_word[SUM_OFS +: NUM_CH] = sum_vec;
            DEC_CHAN: rd_word[CAUSE_W-1:0]       = cause_q[chan_idx];
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            irq_q     <= 1'b0;
        end else begin
            rd_data_q <= rd_word;
            irq_q     <= |sum_nxt;
        end
    end

    assign rd_data = rd_data_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
    parameter int NUM_CH   = 8,
    parameter int CAUSE_W  = 2,
    parameter int SUM_OFS  = 2,
    parameter int ADDR_W   = 5,
    parameter int SUM_ADDR = 0,
    parameter int CH_BASE  = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_CH-1:0][CAUSE_W-1:0] ev_i,
    input logic                           rd_en,
    input logic [ADDR_W-1:0]              rd_addr,
    input logic [31:0]                    rd_data,
    input logic                           irq_o,
    input logic [NUM_CH-1:0]              sum_vec
);
    localparam int TOP_BIT = SUM_OFS + NUM_CH;

    p_irq_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (sum_vec != '0));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0);

    p_sum_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(SUM_ADDR)) |=>
        ((rd_data >> TOP_BIT) == '0) && ((rd_data & ((32'd1 << SUM_OFS) - 32'd1)) == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sum_vec[c] && !(rd_en && rd_addr == ADDR_W'(CH_BASE + c))) |=> sum_vec[c]);

        p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == ADDR_W'(CH_BASE + c) && ev_i[c] == '0) |=> !sum_vec[c]);

        p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_i[c] != '0) |=> sum_vec[c]);
    end
endmodule

bind irq_status_agg irq_status_agg_chk #(
    .NUM_CH  (NUM_CH),
    .CAUSE_W (CAUSE_W),
    .SUM_OFS (SUM_OFS),
    .ADDR_W  (ADDR_W),
    .SUM_ADDR(SUM_ADDR),
    .CH_BASE (CH_BASE)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (ev_i),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .irq_o  (irq_o),
    .sum_vec(sum_vec)
);

// File: tb/irq_status_agg_bench.sv
module irq_status_agg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 8;
    localparam int CAUSE_W    = 2;
    localparam int SUM_OFS    = 2;
    localparam int ADDR_W     = 5;
    localparam int SUM_ADDR   = 0;
    localparam int CH_BASE    = 16;
    localparam logic [ADDR_W-1:0] BAD_ADDR = 5'h1F;

    logic                           clk = 1'b0;
    logic                           rst_n = 1'b0;
    logic [NUM_CH-1:0][CAUSE_W-1:0] ev_i = '0;
    logic                           rd_en = 1'b0;
    logic [ADDR_W-1:0]              rd_addr = '0;
    logic [31:0]                    rd_data;
    logic                           irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [CAUSE_W-1:0] m_cause [NUM_CH];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_agg #(
        .NUM_CH(NUM_CH), .CAUSE_W(CAUSE_W), .SUM_OFS(SUM_OFS),
        .ADDR_W(ADDR_W), .SUM_ADDR(SUM_ADDR), .CH_BASE(CH_BASE)
    ) u_irq_status_agg (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [31:0] model_sum();
        logic [31:0] w = '0;
        for (int c = 0; c < NUM_CH; c++) w[c + SUM_OFS] = |m_cause[c];
        return w;
    endfunction

    function automatic logic [31:0] model_read(logic [ADDR_W-1:0] a);
        logic [31:0] w = '0;
        if (int'(a) == SUM_ADDR) w = model_sum();
        else if (int'(a) >= CH_BASE && int'(a) < CH_BASE + NUM_CH)
            w[CAUSE_W-1:0] = m_cause[int'(a) - CH_BASE];
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock of stimulus; model updated from the requirements, outputs compared after the edge.
    task automatic step(string tag, logic [NUM_CH-1:0][CAUSE_W-1:0] ev,
                        logic re, logic [ADDR_W-1:0] a);
        logic [31:0] exp_rd;
        logic        exp_irq;
        ev_i = ev; rd_en = re; rd_addr = a;
        exp_rd = re ? model_read(a) : 32'd0;
        for (int c = 0; c < NUM_CH; c++) begin
            logic clr = re && (int'(a) == CH_BASE + c);
            m_cause[c] = ev[c] | (clr ? '0 : m_cause[c]);
        end
        exp_irq = model_sum() != 0;
        @(posedge clk);
        #1;
        chk(tag, rd_data, exp_rd);
        chk("R7", {31'd0, irq_o}, {31'd0, exp_irq});
    endtask

    function automatic logic [NUM_CH-1:0][CAUSE_W-1:0] one_ev(int c, logic [CAUSE_W-1:0] v);
        logic [NUM_CH-1:0][CAUSE_W-1:0] e = '0;
        e[c] = v;
        return e;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NUM_CH; c++) m_cause[c] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", rd_data, 32'd0);
        chk("R1", {31'd0, irq_o}, 32'd0);
        step("R1", '0, 1'b1, ADDR_W'(SUM_ADDR));
        // R2: event on channel 3, cause bit 0
        step("R8", one_ev(3, 2'b01), 1'b0, '0);
        step("R2", '0, 1'b1, ADDR_W'(SUM_ADDR));
        // R3: repeated summary reads leave state untouched
        step("R3", '0, 1'b1, ADDR_W'(SUM_ADDR));
        step("R3", '0, 1'b1, ADDR_W'(SUM_ADDR));
        // R4: channel read returns causes and clears
        step("R4", '0, 1'b1, ADDR_W'(CH_BASE + 3));
        step("R4", '0, 1'b1, ADDR_W'(SUM_ADDR));
        // R9: accumulation on channel 0
        step("R9", one_ev(0, 2'b01), 1'b0, '0);
        step("R9", one_ev(0, 2'b10), 1'b0, '0);
        step("R9", '0, 1'b1, ADDR_W'(CH_BASE));
        // R5: collision on channel 7
        step("R5", one_ev(7, 2'b01), 1'b0, '0);
        step("R5", one_ev(7, 2'b10), 1'b1, ADDR_W'(CH_BASE + 7));
        step("R5", '0, 1'b1, ADDR_W'(SUM_ADDR));
        step("R5", '0, 1'b1, ADDR_W'(CH_BASE + 7));
        // R6: unmapped address and reserved bits
        step("R6", one_ev(5, 2'b11), 1'b1, BAD_ADDR);
        step("R6", '0, 1'b1, ADDR_W'(CH_BASE + 5));

        void'($urandom(32'd4242));
        for (int i = 0; i < 600; i++) begin
            logic [NUM_CH-1:0][CAUSE_W-1:0] ev = '0;
            logic re;
            logic [ADDR_W-1:0] a;
            int pick;
            string tag;
            for (int c = 0; c < NUM_CH; c++)
                for (int b = 0; b < CAUSE_W; b++)
                    ev[c][b] = ($urandom_range(0, 11) == 0);
            re = $urandom_range(0, 1) == 1;
            pick = $urandom_range(0, 9);
            if (pick < 3) a = ADDR_W'(SUM_ADDR);
            else if (pick < 9) a = ADDR_W'(CH_BASE + $urandom_range(0, NUM_CH - 1));
            else a = ADDR_W'($urandom_range(1, CH_BASE - 1));
            if (!re) tag = "R8";
            else if (pick < 3) tag = "R3";
            else if (pick < 9) tag = "R4";
            else tag = "R6";
            step(tag, ev, re, a);
        end
        step("R8", '0, 1'b0, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule